// File: doc/BRIEF.md
# Output Compare Unit with Master Channel Override

This block is a timer output stage with several channels. A free-running counter advances by one on each cycle in which the tick enable is high. Each channel holds its own compare value. When the counter steps onto a channel's compare value, that channel applies a two-bit action code to its pin: toggle it, clear it, set it, or leave it alone. Channels other than the top one can also toggle their pin when the counter wraps.

The top channel (index NCH-1) is the master. It raises a master event in two cases: when its own compare matches, and when the counter wraps while its overflow-toggle bit is set. On a master event, every pin whose bit is set in the override mask takes the matching bit of the override level register. For those pins the override beats the channel's own compare. A pin changes only when its output-compare enable bit is 1 and its disconnect bit is 0. Otherwise it keeps its last value.

A write port loads all configuration. Each write is one cycle long and selects its register with a small address.

Top module: `oc_master_unit`

## Requirements
- R1: While reset is high, the counter, every configuration register and every pin are cleared to zero.
- R2: The counter increases by one on each cycle with `tick_en` high and wraps from all ones to zero. The wrap produces an overflow pulse in the next cycle only.
- R3: A channel compares only in the cycle right after a counter step. Its pin changes at the clock edge that ends that cycle, one cycle after the counter edge. A counter that is held still never fires a compare again.
- R4: The action code of channel i sits at `wr_data[2i+1:2i]` at address NCH+5. On that channel's compare, 00 leaves the pin alone, 01 inverts it, 10 drives it to 0 and 11 drives it to 1.
- R5: A master event happens on a compare match of the top channel. It also happens on a counter wrap when bit NCH-1 of the overflow-toggle register (address NCH+2) is set.
- R6: On a master event, each enabled pin whose bit is 1 in the override mask (address NCH) takes the same bit of the override level register (address NCH+1). This holds even if that pin's own compare fires in the same cycle.
- R7: A master event does not change a lower pin whose mask bit is 0. Such a pin follows only its own compare and its overflow toggle.
- R8: A pin is enabled only when its bit in the output-compare enable register (address NCH+3) is 1 and its bit in the disconnect register (address NCH+4) is 0. A pin that is not enabled keeps its value through master events, compares and overflow toggles.
- R9: On a counter wrap, lower channel i inverts its enabled pin when overflow-toggle bit i is set, provided no master override and no own compare applies to that pin in that cycle.
- R10: A write takes effect from the next cycle. An event in the same cycle as a write uses the register values from before the write.
- R11: Addresses 0 to NCH-1 load the compare values of channels 0 to NCH-1. Per-pin registers take their bits from `wr_data[NCH-1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the counter by one in this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register select (AW = clog2(NCH+6)) |
| wr_data | input | CW | Write data |
| pins | output | NCH | Timer output pins |

## Verification
The bench checks the pins in the cycle right after a counter step and again after a long stall. A design that compares on every cycle would keep toggling a pin while the counter is held still. A design without the extra register stage would change the pin one cycle early. The bench runs the counter through a full wrap with the master overflow bit set and one lower overflow toggle enabled. A design that misses the wrap, or that applies the toggle to a masked pin, ends up with wrong pin levels. One master event lands in the same cycle as a pin override, a masked-out pin's own set action, a disconnected pin and a disabled pin. A wrong priority or a missing enable gate shows up as a wrong bit. The bench also writes a new override level in the same cycle as a master event. A design that lets the new value leak into that event drives the new level one event too early.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [1:0] {
        ACT_OFF = 2'b00,
        ACT_TOG = 2'b01,
        ACT_CLR = 2'b10,
        ACT_SET = 2'b11
    } oc_act_e;

    typedef struct packed {
        logic    en;
        logic    msk;
        logic    dat;
        logic    tov;
        oc_act_e act;
    } pin_cfg_t;

    function automatic logic act_apply(oc_act_e a, logic cur);
        case (a)
            ACT_TOG: return ~cur;
            ACT_CLR: return 1'b0;
            ACT_SET: return 1'b1;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    output logic [CW-1:0] cnt,
    output logic          chg,
    output logic          ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            chg <= 1'b0;
            ovf <= 1'b0;
        end else begin
            chg <= tick_en;
            ovf <= tick_en && (cnt == '1);
            if (tick_en) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/oc_match.sv
module oc_match #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic [CW-1:0]           cnt,
    input  logic                    chg,
    input  logic [NCH-1:0][CW-1:0]  cmp,
    output logic [NCH-1:0]          hit
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign hit[g] = chg && (cnt == cmp[g]);
    end
endmodule

// File: rtl/oc_pin_ctrl.sv
module oc_pin_ctrl
    import oc_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       hit,
    input  logic                 ovf,
    input  pin_cfg_t [NCH-1:0]   cfg,
    output logic                 ev7,
    output logic [NCH-1:0]       pins
);
    localparam int TOP = NCH - 1;

    logic [NCH-1:0] nxt;

    assign ev7 = hit[TOP] | (ovf & cfg[TOP].tov);

    for (genvar g = 0; g < NCH; g++) begin : g_pin
        localparam bit IS_TOP = (g == TOP);
        logic nb;
        always_comb begin
            nb = pins[g];
            if (cfg[g].en) begin
                if (ev7 && cfg[g].msk)
                    nb = cfg[g].dat;
                else if (hit[g])
                    nb = act_apply(cfg[g].act, pins[g]);
                else if (!IS_TOP && ovf && cfg[g].tov)
                    nb = ~pins[g];
            end
        end
        assign nxt[g] = nb;
    end

    always_ff @(posedge clk) begin
        if (rst) pins <= '0;
        else     pins <= nxt;
    end
endmodule

// File: rtl/oc_master_unit.sv
module oc_master_unit
    import oc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    localparam int AW = $clog2(NCH + 6)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [NCH-1:0] pins
);
    localparam logic [AW-1:0] A_MASK = AW'(NCH);
    localparam logic [AW-1:0] A_DATA = AW'(NCH + 1);
    localparam logic [AW-1:0] A_TOV  = AW'(NCH + 2);
    localparam logic [AW-1:0] A_IOS  = AW'(NCH + 3);
    localparam logic [AW-1:0] A_OCPD = AW'(NCH + 4);
    localparam logic [AW-1:0] A_ACT  = AW'(NCH + 5);

    logic [NCH-1:0][CW-1:0] cmp_q;
    logic [NCH-1:0]         mask_q, data_q, tov_q, ios_q, ocpd_q, pin_en;
    logic [2*NCH-1:0]       act_q;
    logic [CW-1:0]          cnt;
    logic                   chg, ovf, ev7;
    logic [NCH-1:0]         hit;
    pin_cfg_t [NCH-1:0]     cfg;

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst)                                cmp_q[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))    cmp_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            data_q <= '0;
            tov_q  <= '0;
            ios_q  <= '0;
            ocpd_q <= '0;
            act_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MASK:  mask_q <= wr_data[NCH-1:0];
                A_DATA:  data_q <= wr_data[NCH-1:0];
                A_TOV:   tov_q  <= wr_data[NCH-1:0];
                A_IOS:   ios_q  <= wr_data[NCH-1:0];
                A_OCPD:  ocpd_q <= wr_data[NCH-1:0];
                A_ACT:   act_q  <= wr_data[2*NCH-1:0];
                default: ;
            endcase
        end
    end

    assign pin_en = ios_q & ~ocpd_q;

    for (genvar g = 0; g < NCH; g++) begin : g_cfg
        assign cfg[g] = '{en:  pin_en[g],
                          msk: mask_q[g],
                          dat: data_q[g],
                          tov: tov_q[g],
                          act: oc_act_e'(act_q[2*g +: 2])};
    end

    oc_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .cnt(cnt), .chg(chg), .ovf(ovf)
    );

    oc_match #(.NCH(NCH), .CW(CW)) u_match (
        .cnt(cnt), .chg(chg), .cmp(cmp_q), .hit(hit)
    );

    oc_pin_ctrl #(.NCH(NCH)) u_pin (
        .clk(clk), .rst(rst), .hit(hit), .ovf(ovf),
        .cfg(cfg), .ev7(ev7), .pins(pins)
    );
endmodule

// File: rtl/oc_master_unit_chk.sv
module oc_master_unit_chk #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           tick_en,
    input logic [NCH-1:0] pins,
    input logic [CW-1:0]  cnt,
    input logic           ovf,
    input logic           ev7,
    input logic [NCH-1:0] mask_q,
    input logic [NCH-1:0] data_q,
    input logic [NCH-1:0] pin_en
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pins == '0 && cnt == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> cnt == CW'($past(cnt) + 1'b1));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));

    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ovf |-> cnt == '0);

    assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(tick_en, 2) |-> $stable(pins));

    assert_override_level_R6: assert property (@(posedge clk) disable iff (rst)
        ev7 |=> ((pins ^ $past(data_q)) & $past(mask_q & pin_en)) == '0);

    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ((pins ^ $past(pins)) & ~$past(pin_en)) == '0);
endmodule

bind oc_master_unit oc_master_unit_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .pins(pins), .cnt(cnt),
    .ovf(ovf), .ev7(ev7), .mask_q(mask_q), .data_q(data_q), .pin_en(pin_en)
);

// File: tb/test_oc_master_unit.sv
`timescale 1ns/1ps
module test_oc_master_unit;
    localparam int NCH = 8;
    localparam int CW  = 16;
    localparam int AW  = $clog2(NCH + 6);
    localparam logic [AW-1:0] A_MASK = AW'(NCH);
    localparam logic [AW-1:0] A_DATA = AW'(NCH + 1);
    localparam logic [AW-1:0] A_TOV  = AW'(NCH + 2);
    localparam logic [AW-1:0] A_IOS  = AW'(NCH + 3);
    localparam logic [AW-1:0] A_OCPD = AW'(NCH + 4);
    localparam logic [AW-1:0] A_ACT  = AW'(NCH + 5);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [NCH-1:0] pins;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    oc_master_unit #(.NCH(NCH), .CW(CW)) i_oc_master_unit (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pins(pins)
    );

    task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // leaves the bench at the negedge right after the n-th counter step
    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset pins", pins, 8'h00);
        rst = 1'b0;

        // R11 map: cmp0..3=5, cmp4,5,7=10; pin5 disconnected, pins 6,7 disabled
        for (int c = 0; c < 4; c++) wr(AW'(c), 16'd5);
        wr(AW'(4), 16'd10);
        wr(AW'(5), 16'd10);
        wr(AW'(7), 16'd10);
        wr(A_IOS, 16'h003F);
        wr(A_OCPD, 16'h0020);
        // R4 codes: ch0 toggle, ch1 set, ch2 clear, ch3 off, ch4 set, ch5 set
        wr(A_ACT, 16'h0F2D);

        tick(4);
        idle(1);
        check("R3 no fire before match", pins, 8'h00);
        tick(1);
        check("R3 one cycle latency", pins, 8'h00);
        idle(1);
        check("R4 action codes", pins, 8'h03);
        idle(10);
        check("R3 stalled counter no refire", pins, 8'h03);

        // master event at count 10
        wr(A_MASK, 16'h004F);
        wr(A_DATA, 16'h004A);
        tick(5);
        idle(1);
        check("R6 masked pins take level", pins & 8'h0F, 8'h0A);
        check("R7 unmasked pin follows own compare", pins & 8'h10, 8'h10);
        check("R8 disabled and disconnected pins hold", pins & 8'hE0, 8'h00);

        // wrap: master overflow event plus lower toggle on pin2
        wr(A_TOV, 16'h0084);
        wr(A_MASK, 16'h0003);
        wr(A_DATA, 16'h0001);
        tick(65525);
        idle(1);
        check("R5 no event before wrap", pins, 8'h1A);
        tick(1);
        idle(1);
        check("R5 overflow master event", pins & 8'h03, 8'h01);
        check("R9 overflow toggle lower pin", pins & 8'h1C, 8'h1C);
        check("R2 wrap reached with full pin state", pins, 8'h1D);

        // R10: write coinciding with a master event
        wr(A_MASK, 16'h0001);
        wr(A_DATA, 16'h0000);
        wr(AW'(7), 16'd3);
        tick(3);
        wr_en = 1'b1; wr_addr = A_DATA; wr_data = 16'h0001;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 event uses old level", pins, 8'h1C);
        wr(AW'(7), 16'd4);
        tick(1);
        idle(1);
        check("R10 new level applies later", pins, 8'h1D);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule